// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects eight interrupt request lines, decides which of them may interrupt the processor, and returns an 8-bit vector when the processor acknowledges. Software programs it through a small register port. The port has one address bit, an 8-bit write bus, a select and separate read and write strobes. Writes are decoded by context. A restart word opens an initialization sequence: a vector base always follows, then a cascade byte unless single mode was chosen, then a mode byte if the restart word asked for one. After that sequence, writes at address 1 load the mask register. Writes at address 0 are command words that end service of a level or that choose the readback register and the special mask mode.

Priority is fixed, with input 0 highest. A pending, unmasked request raises the interrupt output only when it outranks every level now in service. An acknowledge moves the winning level from the request register to the in-service register and delivers base plus level number as the vector one cycle later. The cascade byte and the mode byte are stored and brought out as outputs. No cascade bus is driven.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers read 0, the interrupt output is low, no vector is valid and readback at address 0 selects the request register.
- R2: A write at address 0 with data bit 4 set restarts initialization. It clears the mask register, the in-service register, special mask mode and the edge history, and it selects the request register for readback. Its bit 3 picks level (1) or edge (0) sensing, bit 1 picks single mode and bit 0 requests a mode byte.
- R3: Address-1 writes during initialization are taken in order as the vector base, then the cascade byte (skipped in single mode), then the mode byte (skipped unless requested). The cascade byte appears on casc_cfg and the low five bits of the mode byte appear on icw4_mode, where bit 1 is automatic end of service. The interrupt output stays low until the sequence is complete.
- R4: Once initialization is complete, an address-1 write loads the mask register and an address-1 read returns it. A 1 in the mask blocks that input, so 0xFF blocks every input.
- R5: A write at address 0 with bits 4:3 = 01 selects the readback. Bits 1:0 = 10 select the request register, 11 select the in-service register, and 0x leave the choice as it was. An address-0 read returns the selected register.
- R6: In edge mode a request bit is set by a 0-to-1 change of its input, and an input held high does not set it again after acknowledge. In level mode the request register follows the inputs.
- R7: The interrupt output is high only when the lowest-numbered unmasked request has a lower number than every in-service bit.
- R8: An acknowledge while the output is high clears that request bit and sets its in-service bit. On the next cycle vec_valid is high for one cycle and vec_out equals base plus the level number.
- R9: With automatic end of service selected, an acknowledge leaves the in-service register unchanged.
- R10: An address-0 write of the form 001xxxxx clears the lowest-numbered in-service bit. A write of the form 011xxnnn clears in-service bit nnn.
- R11: Command bits 6:5 = 11 set special mask mode and 10 clear it. While the mode is set, in-service bits that are masked do not block requests.
- R12: An acknowledge while the output is low returns base plus 7 and leaves the request and in-service registers unchanged.
- R13: An acknowledge and an end-of-service write in the same cycle both take effect. The end-of-service choice is made on the in-service contents from before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register port select |
| addr | input | 1 | Register port address bit |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when not reading) |
| irq_in | input | 8 | Interrupt request inputs, 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector delivered after acknowledge |
| vec_valid | output | 1 | vec_out is valid this cycle |
| casc_cfg | output | 8 | Stored cascade byte |
| icw4_mode | output | 5 | Stored mode byte, low five bits |

## Verification
The clash that matters most is an acknowledge and an end-of-service command in the same clock. One test sets up level 5 in service with level 2 pending. It then asserts the acknowledge together with a non-specific end-of-service write. Only level 5 may be cleared, level 2 must become in service, and the vector must name level 2. A second overlap is a held input against acknowledge in edge mode: the bench keeps the line high and checks that the request bit does not come back.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic [7:0] casc_cfg,
  output logic [4:0] icw4_mode
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} st_t;
  st_t st;

  logic [7:0] irr, isr, imr, irq_d, base;
  logic lvl, single, need4, smm, rsel;
  logic [7:0] req, blk, req_lo, blk_lo, ack_set, eoi_clr, irr_nxt;
  logic [2:0] win;

  wire we     = sel & wr;
  wire w_init = we & ~addr & wdata[4];
  wire w_sel  = we & ~addr & ~wdata[4] & wdata[3];
  wire w_eoi  = we & ~addr & (wdata[4:3] == 2'b00);
  wire busy   = (st != ST_RUN);
  wire aeoi   = icw4_mode[1];

  assign req     = irr & ~imr;
  assign blk     = smm ? (isr & ~imr) : isr;
  assign req_lo  = req & (~req + 8'd1);
  assign blk_lo  = blk & (~blk + 8'd1);
  assign int_out = !busy && (req_lo != 8'd0) && ((blk_lo == 8'd0) || (req_lo < blk_lo));

  always_comb begin
    win = 3'd7;
    for (int i = 7; i >= 0; i--)
      if (req_lo[i]) win = 3'(i);
  end

  wire take = ack & int_out;
  assign ack_set = take ? req_lo : 8'd0;

  always_comb begin
    eoi_clr = 8'd0;
    if (w_eoi && wdata[7:5] == 3'b001) eoi_clr = isr & (~isr + 8'd1);
    else if (w_eoi && wdata[7:5] == 3'b011) eoi_clr = 8'd1 << wdata[2:0];
  end

  assign irr_nxt = (lvl ? irq_in : (irr | (irq_in & ~irq_d))) & ~ack_set;

  assign rdata = (sel & rd) ? (addr ? imr : (rsel ? isr : irr)) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RUN;
      irr <= '0; isr <= '0; imr <= '0; irq_d <= '0; base <= '0;
      lvl <= 1'b0; single <= 1'b1; need4 <= 1'b0; smm <= 1'b0; rsel <= 1'b0;
      casc_cfg <= '0; icw4_mode <= '0;
      vec_out <= '0; vec_valid <= 1'b0;
    end else begin
      irr <= irr_nxt;
      vec_valid <= ack;
      if (ack) vec_out <= base + {5'd0, take ? win : 3'd7};
      if (w_init) begin
        st <= ST_BASE;
        imr <= '0; isr <= '0; smm <= 1'b0; rsel <= 1'b0; irq_d <= '0;
        lvl <= wdata[3]; single <= wdata[1]; need4 <= wdata[0];
        icw4_mode <= '0;
      end else begin
        irq_d <= irq_in;
        isr <= (isr & ~eoi_clr) | (aeoi ? 8'd0 : ack_set);
        if (we && addr) begin
          case (st)
            ST_BASE: begin
              base <= wdata;
              st <= !single ? ST_CASC : (need4 ? ST_MODE : ST_RUN);
            end
            ST_CASC: begin
              casc_cfg <= wdata;
              st <= need4 ? ST_MODE : ST_RUN;
            end
            ST_MODE: begin
              icw4_mode <= wdata[4:0];
              st <= ST_RUN;
            end
            default: imr <= wdata;
          endcase
        end
        if (w_sel) begin
          if (wdata[6]) smm <= wdata[5];
          if (wdata[1]) rsel <= wdata[0];
        end
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       ack,
  input logic       int_out,
  input logic       vec_valid,
  input logic       busy,
  input logic       aeoi,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr
);
  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != 8'd0)); // R7
  AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !int_out); // R3
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid); // R8
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid); // R8
  AST_AUTO_EOI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && ack && !(we && !addr)) |=> $stable(isr)); // R9
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr && wdata[4]) |=> (imr == 8'd0 && isr == 8'd0)); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr && !busy) |=> (imr == $past(wdata))); // R4
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .ack(ack),
  .int_out(int_out), .vec_valid(vec_valid), .busy(busy), .aeoi(aeoi),
  .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, addr = 0, wr = 0, rd = 0, ack = 0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, casc_cfg;
  logic [4:0] icw4_mode;
  logic int_out, vec_valid;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid),
    .casc_cfg(casc_cfg), .icw4_mode(icw4_mode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; addr = 0; wdata = '0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    sel = 1; rd = 1; addr = a; #1; d = rdata; sel = 0; rd = 0; addr = 0;
  endtask

  task automatic set_irq(input logic [7:0] x);
    @(negedge clk); irq_in = x;
    @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_reset;
    rd_reg(1'b1, v); chk("R1 mask", v, 8'h00);
    rd_reg(1'b0, v); chk("R1 request", v, 8'h00);
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_init_seq;
    wr_reg(1'b0, 8'h11);
    set_irq(8'h01);
    chk("R3 int low during init", {7'd0, int_out}, 8'h00);
    wr_reg(1'b1, 8'h20);
    wr_reg(1'b1, 8'h04);
    chk("R3 int low before mode byte", {7'd0, int_out}, 8'h00);
    wr_reg(1'b1, 8'h01);
    chk("R3 cascade byte", casc_cfg, 8'h04);
    chk("R3 mode byte", {3'd0, icw4_mode}, 8'h01);
    chk("R3 int after init", {7'd0, int_out}, 8'h01);
    do_ack;
    chk("R8 vector level0", vec_out, 8'h20);
    wr_reg(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_mask;
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, v); chk("R4 mask readback", v, 8'hFF);
    set_irq(8'h08);
    rd_reg(1'b0, v); chk("R5 default request read", v, 8'h08);
    chk("R4 all masked", {7'd0, int_out}, 8'h00);
    wr_reg(1'b1, 8'hF7);
    chk("R4 unmasked level3", {7'd0, int_out}, 8'h01);
  endtask

  task automatic t_ack;
    do_ack;
    chk("R8 vector level3", vec_out, 8'h23);
    chk("R8 vec_valid", {7'd0, vec_valid}, 8'h01);
    rd_reg(1'b0, v); chk("R6 held edge not re-requested", v, 8'h00);
    wr_reg(1'b0, 8'h0B);
    chk("R8 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
    rd_reg(1'b0, v); chk("R5 in-service read", v, 8'h08);
    chk("R8 int dropped", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_priority;
    wr_reg(1'b1, 8'h00);
    set_irq(8'h28);
    chk("R7 lower level blocked", {7'd0, int_out}, 8'h00);
    set_irq(8'h2A);
    chk("R7 higher level passes", {7'd0, int_out}, 8'h01);
    do_ack;
    chk("R8 vector level1", vec_out, 8'h21);
    rd_reg(1'b0, v); chk("R8 in-service nested", v, 8'h0A);
  endtask

  task automatic t_eoi;
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, v); chk("R10 non-specific", v, 8'h08);
    wr_reg(1'b0, 8'h63);
    rd_reg(1'b0, v); chk("R10 specific", v, 8'h00);
    chk("R10 level5 now wins", {7'd0, int_out}, 8'h01);
  endtask

  task automatic t_overlap;
    do_ack;
    chk("R8 vector level5", vec_out, 8'h25);
    set_irq(8'h2E);
    chk("R13 level2 pending", {7'd0, int_out}, 8'h01);
    @(negedge clk); ack = 1; sel = 1; wr = 1; addr = 0; wdata = 8'h20;
    @(negedge clk); ack = 0; sel = 0; wr = 0; wdata = '0;
    chk("R13 vector level2", vec_out, 8'h22);
    rd_reg(1'b0, v); chk("R13 eoi and ack combined", v, 8'h04);
  endtask

  task automatic t_special_mask;
    set_irq(8'h6E);
    chk("R11 blocked by level2", {7'd0, int_out}, 8'h00);
    wr_reg(1'b0, 8'h68);
    chk("R11 mode on, level2 unmasked", {7'd0, int_out}, 8'h00);
    wr_reg(1'b1, 8'h04);
    chk("R11 masked service ignored", {7'd0, int_out}, 8'h01);
    wr_reg(1'b0, 8'h48);
    chk("R11 mode off", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_level_aeoi;
    set_irq(8'h00);
    wr_reg(1'b0, 8'h1B);
    rd_reg(1'b1, v); chk("R2 mask cleared", v, 8'h00);
    wr_reg(1'b1, 8'h40);
    rd_reg(1'b0, v); chk("R2 readback back to request", v, 8'h00);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, v); chk("R2 in-service cleared", v, 8'h00);
    wr_reg(1'b1, 8'h02);
    chk("R3 auto mode stored", {3'd0, icw4_mode}, 8'h02);
    wr_reg(1'b0, 8'h0A);
    set_irq(8'h10);
    rd_reg(1'b0, v); chk("R6 level follows", v, 8'h10);
    do_ack;
    chk("R8 vector base 0x40", vec_out, 8'h44);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, v); chk("R9 auto end of service", v, 8'h00);
    set_irq(8'h00);
    chk("R6 level dropped", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_spurious;
    do_ack;
    chk("R12 spurious vector", vec_out, 8'h47);
    rd_reg(1'b0, v); chk("R12 in-service unchanged", v, 8'h00);
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, v); chk("R12 request unchanged", v, 8'h00);
  endtask

  task automatic t_short_init;
    wr_reg(1'b0, 8'h12);
    wr_reg(1'b1, 8'h50);
    chk("R3 no mode byte", {3'd0, icw4_mode}, 8'h00);
    wr_reg(1'b1, 8'h5A);
    rd_reg(1'b1, v); chk("R4 mask after short init", v, 8'h5A);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_init_seq;
    t_mask;
    t_ack;
    t_priority;
    t_eoi;
    t_overlap;
    t_special_mask;
    t_level_aeoi;
    t_spurious;
    t_short_init;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule